// File: doc/BRIEF.md
# Call/Return Frame Sequencer

This block carries out the memory side of a subroutine call or return for a small 32-bit processor core. The core presents a one-cycle start pulse together with the operation kind, the address of the calling instruction, the encoding form of the call, the call destination, and its current frame and stack pointers. The sequencer then performs two word transfers on a single memory request channel. It reports the new frame pointer, stack pointer and program counter together with a one-cycle completion pulse.

A call frame holds three words below the caller's stack pointer. The highest word is a spare slot that is never written. Below it sits the return address, and the lowest word holds the caller's frame pointer. After a call, the frame and stack pointers both point at the saved frame-pointer word. A return does not use the stack pointer it is given. It unwinds from the frame pointer: it reloads the old frame pointer and the return address from the frame, then moves the stack pointer past all three words.

The memory channel is valid/ready. The sequencer raises `mem_valid_o` and holds address, write enable and write data unchanged until it samples `mem_ready_i` high on a rising edge. On that edge the transfer completes, and for a read `mem_rdata_i` is taken on the same edge. Memory may hold `mem_ready_i` low for any number of cycles. Only one transfer is outstanding at a time. The start input is a plain control pin and is not handshaked.

Top module: `callret_seq`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `done_o` and `mem_valid_o` are 0, and `fp_o`, `sp_o` and `pc_o` are 0 until the first completion.
- R2: On a call (`op_i`=0), the first transfer is a write (`mem_we_o`=1) of the return address to the old stack pointer minus 8.
- R3: The return address is the calling instruction's address plus 2 when `form_i`=0 (register form) and plus 6 when `form_i`=1 (absolute form).
- R4: The second transfer of a call writes the old frame pointer to the old stack pointer minus 12.
- R5: When a call completes, `fp_o` and `sp_o` both equal the old stack pointer minus 12, and `pc_o` equals `target_i`.
- R6: On a return (`op_i`=1), two reads (`mem_we_o`=0) are made: first at the old frame pointer, then at the old frame pointer plus 4. On completion, `fp_o` is the first word read, `pc_o` is the second word read, and `sp_o` is the old frame pointer plus 12.
- R7: A request holds its address, write enable and data stable until accepted by `mem_ready_i`. The sequencer moves to the next transfer only after an accepted handshake, and each operation makes exactly two transfers.
- R8: A start pulse while `busy_o` is high is ignored: it does not restart the sequence, change the operation, or add transfers.
- R9: `done_o` is high for exactly one cycle per operation. `fp_o`, `sp_o` and `pc_o` change only in that cycle and hold their values until the next completion.
- R10: All pointer arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| op_i | input | 1 | 0 = call, 1 = return |
| form_i | input | 1 | Call form: 0 = register (+2), 1 = absolute (+6) |
| pc_i | input | 32 | Address of the calling instruction |
| target_i | input | 32 | Call destination |
| fp_i | input | 32 | Current frame pointer |
| sp_i | input | 32 | Current stack pointer |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word address (byte units, aligned) |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, taken on the accepting edge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fp_o | output | 32 | Resulting frame pointer |
| sp_o | output | 32 | Resulting stack pointer |
| pc_o | output | 32 | Resulting program counter |

## Verification
The bench drives calls in both encoding forms and returns, with memory latencies from zero to three wait cycles. A design that advanced without a handshake would drop a transfer or shift its address. A design that used the wrong length for one form would write a return address off by four.

Stack pointers near zero and frame pointers near the top of the address space test wraparound. A design that mixed widths or saturated there would produce addresses that are far off.

A second start pulse is injected while a call is in flight, with the opposite operation and different pointers. A design that restarted would issue extra transfers or report pointers derived from the injected values.

After a return, the bench checks that the stack pointer comes from the frame pointer and not from `sp_i`.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_RA = 3'd1,
    ST_PUSH_FP = 3'd2,
    ST_POP_FP  = 3'd3,
    ST_POP_PC  = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_e;

  localparam logic OP_CALL = 1'b0;
  localparam logic OP_RET  = 1'b1;

  // frame layout in words below the caller's stack pointer
  localparam int SLOT_LINK  = 2;  // return address
  localparam int SLOT_FRAME = 3;  // saved frame pointer
  localparam int FRAME_WORDS = 3; // total reserved on call

endpackage

// File: rtl/callret_link.sv
// Return address: caller PC advanced by the length of the call encoding.
module callret_link #(
  parameter int XLEN      = 32,
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 6
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            long_i,
  output logic [XLEN-1:0] link_o
);
  localparam logic [XLEN-1:0] SHORT_STEP = XLEN'(SHORT_LEN);
  localparam logic [XLEN-1:0] LONG_STEP  = XLEN'(LONG_LEN);

  // R3: length selected by call form
  always_comb begin
    link_o = pc_i + (long_i ? LONG_STEP : SHORT_STEP);
  end
endmodule

// File: rtl/callret_fsm.sv
module callret_fsm
  import callret_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       is_ret_i,
  input  logic       mem_ready_i,
  output seq_state_e state_o,
  output logic       accept_o
);
  seq_state_e state_q, state_d;

  // R8: a start is taken only in the idle state
  assign accept_o = start_i && (state_q == ST_IDLE);
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept_o) state_d = is_ret_i ? ST_POP_FP : ST_PUSH_RA;
      ST_PUSH_RA: if (mem_ready_i) state_d = ST_PUSH_FP;
      ST_PUSH_FP: if (mem_ready_i) state_d = ST_DONE;
      ST_POP_FP:  if (mem_ready_i) state_d = ST_POP_PC;
      ST_POP_PC:  if (mem_ready_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/callret_addr.sv
// Request generator: address, direction and data per memory state.
module callret_addr
  import callret_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4
) (
  input  seq_state_e      state_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] link_i,
  input  logic [XLEN-1:0] fp_save_i,
  output logic            valid_o,
  output logic            we_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] wdata_o
);
  localparam logic [XLEN-1:0] OFF_WORD  = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] OFF_LINK  = XLEN'(SLOT_LINK * WORD_BYTES);
  localparam logic [XLEN-1:0] OFF_FRAME = XLEN'(SLOT_FRAME * WORD_BYTES);

  always_comb begin
    valid_o = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_PUSH_RA: begin // R2
        valid_o = 1'b1;
        we_o    = 1'b1;
        addr_o  = base_i - OFF_LINK;
        wdata_o = link_i;
      end
      ST_PUSH_FP: begin // R4
        valid_o = 1'b1;
        we_o    = 1'b1;
        addr_o  = base_i - OFF_FRAME;
        wdata_o = fp_save_i;
      end
      ST_POP_FP: begin // R6
        valid_o = 1'b1;
        addr_o  = base_i;
      end
      ST_POP_PC: begin // R6
        valid_o = 1'b1;
        addr_o  = base_i + OFF_WORD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4,
  parameter int SHORT_LEN  = 2,
  parameter int LONG_LEN   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            op_i,
  input  logic            form_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] fp_i,
  input  logic [XLEN-1:0] sp_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] fp_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] pc_o
);
  localparam logic [XLEN-1:0] FRAME_SPAN = XLEN'(FRAME_WORDS * WORD_BYTES);

  seq_state_e      state;
  logic            accept;
  logic            xfer;
  logic [XLEN-1:0] link_d;

  logic [XLEN-1:0] base_q;    // call: old SP, return: old FP
  logic [XLEN-1:0] link_q;
  logic [XLEN-1:0] fpsave_q;
  logic [XLEN-1:0] target_q;
  logic [XLEN-1:0] popfp_q;
  logic [XLEN-1:0] fp_q, sp_q, pc_q;

  callret_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .is_ret_i    (op_i),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .accept_o    (accept)
  );

  callret_link #(
    .XLEN      (XLEN),
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) u_link (
    .pc_i   (pc_i),
    .long_i (form_i),
    .link_o (link_d)
  );

  callret_addr #(
    .XLEN       (XLEN),
    .WORD_BYTES (WORD_BYTES)
  ) u_addr (
    .state_i   (state),
    .base_i    (base_q),
    .link_i    (link_q),
    .fp_save_i (fpsave_q),
    .valid_o   (mem_valid_o),
    .we_o      (mem_we_o),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o)
  );

  assign xfer = mem_valid_o && mem_ready_i;

  // operands captured once per accepted start (R8)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      link_q   <= '0;
      fpsave_q <= '0;
      target_q <= '0;
    end else if (accept) begin
      base_q   <= (op_i == OP_RET) ? fp_i : sp_i;
      link_q   <= link_d;
      fpsave_q <= fp_i;
      target_q <= target_i;
    end
  end

  // popped frame pointer parked until the frame is fully unwound
  always_ff @(posedge clk) begin
    if (!rst_n)                             popfp_q <= '0;
    else if (xfer && state == ST_POP_FP)    popfp_q <= mem_rdata_i;
  end

  // results committed on the edge that enters ST_DONE (R9)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp_q <= '0;
      sp_q <= '0;
      pc_q <= '0;
    end else if (xfer && state == ST_PUSH_FP) begin // R5
      fp_q <= base_q - FRAME_SPAN;
      sp_q <= base_q - FRAME_SPAN;
      pc_q <= target_q;
    end else if (xfer && state == ST_POP_PC) begin  // R6
      fp_q <= popfp_q;
      sp_q <= base_q + FRAME_SPAN;
      pc_q <= mem_rdata_i;
    end
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);
  assign fp_o   = fp_q;
  assign sp_o   = sp_q;
  assign pc_o   = pc_q;

endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            op_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            mem_valid_o,
  input logic            mem_ready_i,
  input logic            mem_we_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic [XLEN-1:0] fp_o,
  input logic [XLEN-1:0] sp_o,
  input logic [XLEN-1:0] pc_o
);
  logic is_ret_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 is_ret_q <= 1'b0;
    else if (start_i && !busy_o) is_ret_q <= op_i;
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R7
  req_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> busy_o);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(fp_o) && $stable(sp_o) && $stable(pc_o));

  // R8
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o);

  // R2
  call_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !is_ret_q |-> mem_we_o);

  // R6
  ret_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && is_ret_q |-> !mem_we_o);

  // R5
  call_fp_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !is_ret_q |-> fp_o == sp_o);

endmodule

bind callret_seq callret_seq_chk #(.XLEN(XLEN)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .op_i        (op_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .fp_o        (fp_o),
  .sp_o        (sp_o),
  .pc_o        (pc_o)
);

// File: tb/callret_seq_tb_top.sv
module callret_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        op;
    logic        form;
    logic [31:0] pc;
    logic [31:0] target;
    logic [31:0] fp;
    logic [31:0] sp;
    logic [3:0]  lat;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 32'h0000_1000, 32'h0000_2000, 32'h0000_8000, 32'h0000_7FF0, 4'd0},
    '{1'b0, 1'b1, 32'h0000_1234, 32'h0000_ABC0, 32'h0000_9000, 32'h0000_8F00, 4'd2},
    '{1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_7FE4, 32'h0000_7000, 4'd0},
    '{1'b1, 1'b1, 32'h0000_0040, 32'h0000_0080, 32'h0000_0100, 32'h0000_0000, 4'd3},
    '{1'b0, 1'b1, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_0010, 32'h0000_0004, 4'd1},
    '{1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFF8, 32'h0000_0020, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic        form_i = 1'b0;
  logic [31:0] pc_i = '0, target_i = '0, fp_i = '0, sp_i = '0;
  logic        mem_valid_o, mem_we_o, busy_o, done_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, fp_o, sp_o, pc_o;
  logic [31:0] mem_rdata_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int wcnt = 0;
  int log_n = 0;
  logic [31:0] log_addr [8];
  logic [31:0] log_data [8];
  logic        log_we   [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  callret_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .form_i(form_i),
    .pc_i(pc_i), .target_i(target_i), .fp_i(fp_i), .sp_i(sp_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .fp_o(fp_o), .sp_o(sp_o), .pc_o(pc_o)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  // memory responder, driven away from the active edge
  always @(negedge clk) begin
    if (mem_ready_i) begin
      mem_ready_i <= 1'b0;
      wcnt = 0;
    end else if (mem_valid_o) begin
      if (wcnt >= lat) begin
        mem_ready_i <= 1'b1;
        mem_rdata_i <= memf(mem_addr_o);
        if (log_n < 8) begin
          log_addr[log_n] = mem_addr_o;
          log_data[log_n] = mem_wdata_o;
          log_we[log_n]   = mem_we_o;
        end
        log_n = log_n + 1;
      end else begin
        wcnt = wcnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    int cyc;
    logic [31:0] ra, f0, s0, p0;
    log_n = 0;
    lat = int'(v.lat);
    @(negedge clk);
    op_i = v.op; form_i = v.form; pc_i = v.pc; target_i = v.target;
    fp_i = v.fp; sp_i = v.sp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      op_i = ~v.op; sp_i = 32'hDEAD_0000; fp_i = 32'hBEEF_0000; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 done seen", {31'd0, done_o}, 32'd1);
    f0 = fp_o; s0 = sp_o; p0 = pc_o;
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done_o}, 32'd0);
    chk("R7 transfer count", log_n, 32'd2);
    ra = v.pc + (v.form ? 32'd6 : 32'd2);
    if (v.op == 1'b0) begin
      chk("R2 first is write", {31'd0, log_we[0]}, 32'd1);
      chk("R2 link address", log_addr[0], v.sp - 32'd8);
      chk("R3 link value", log_data[0], ra);
      chk("R4 frame write", {31'd0, log_we[1]}, 32'd1);
      chk("R4 frame address", log_addr[1], v.sp - 32'd12);
      chk("R4 frame value", log_data[1], v.fp);
      chk("R5 fp", f0, v.sp - 32'd12);
      chk("R5 sp", s0, v.sp - 32'd12);
      chk("R5 pc", p0, v.target);
    end else begin
      chk("R6 first is read", {31'd0, log_we[0]}, 32'd0);
      chk("R6 first address", log_addr[0], v.fp);
      chk("R6 second is read", {31'd0, log_we[1]}, 32'd0);
      chk("R6 second address", log_addr[1], v.fp + 32'd4);
      chk("R6 fp", f0, memf(v.fp));
      chk("R6 pc", p0, memf(v.fp + 32'd4));
      chk("R6 sp", s0, v.fp + 32'd12);
    end
    repeat (4) @(negedge clk);
    chk("R9 fp hold", fp_o, f0);
    chk("R9 sp hold", sp_o, s0);
    chk("R9 pc hold", pc_o, p0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 busy in reset", {31'd0, busy_o}, 32'd0);
    chk("R1 valid in reset", {31'd0, mem_valid_o}, 32'd0);
    chk("R1 done in reset", {31'd0, done_o}, 32'd0);
    chk("R1 fp in reset", fp_o, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {29'd0, busy_o, mem_valid_o, done_o}, 32'd0);
    chk("R1 sp after reset", sp_o, 32'd0);
    chk("R1 pc after reset", pc_o, 32'd0);

    // vector table: calls, returns, latencies, R10 wraparound (entries 4 and 5)
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 1'b0);

    // R8: second start while busy with opposite op and different pointers
    run_vec('{1'b0, 1'b1, 32'h0000_0300, 32'h0000_0500, 32'h0000_6000, 32'h0000_5000, 4'd3}, 1'b1);
    run_vec('{1'b1, 1'b0, 32'h0, 32'h0, 32'h0000_4444, 32'h0000_1000, 4'd2}, 1'b1);

    // R10: call with stack pointer zero
    run_vec('{1'b0, 1'b0, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 32'h0000_0000, 4'd0}, 1'b0);

    // R1: reset in the middle of an operation
    lat = 5;
    @(negedge clk);
    op_i = 1'b0; sp_i = 32'h100; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset busy", {31'd0, busy_o}, 32'd0);
    chk("R1 mid reset valid", {31'd0, mem_valid_o}, 32'd0);
    chk("R1 mid reset fp", fp_o, 32'd0);
    summary();
  end
endmodule